// File: doc/BRIEF.md
# Turbo CPU Slow-Bus Synchronizer

This block sits between a processor clocked at four times the rate of an older system bus and that bus itself. On every processor access it decides from the eight-bit bank field of the 24-bit address whether the access goes to fast local memory or to the legacy bus. Fast accesses complete in the same cycle. Slow accesses hold the processor's wait line until the next slow-bus cycle boundary, run one complete slow cycle, and return the captured data on the cycle that drops the wait line.

Bank zero always maps to the legacy bus. A turbo-disable pin sends every memory access down the slow path. So does a software bit held in a small identity/control register. That register answers with no stall from a fixed page in the top bank. It returns an identity code in its upper bits and the software slow bit in bit 0. A free-running phase counter produces the slow clock and sets where each slow cycle may start. A stalled access therefore costs between one and two slow periods, depending on the phase at which it arrives.

Top module: `turbo_bus_sync`

## Requirements
- R1: While reset is held, `cpu_wait` and `sb_cyc` are low. After reset the software slow bit is 0, so a read of the control register returns `{ID_CODE, 1'b0}` (0x5A with default parameters).
- R2: An access whose bank (address bits 23:16) is not 0, with turbo disable and software slow both clear, is fast. `cpu_wait` stays low, `fm_en` is high with `fm_we`, `fm_addr` and `fm_wdata` taken from the processor, and `cpu_rdata` equals `fm_rdata` in the same cycle.
- R3: The phase counter is 0 in the first cycle after reset is released and advances by one every fast cycle. A slow access presented in a cycle at phase p holds `cpu_wait` high for 4 cycles when p is 0 and for 8−p cycles otherwise. The access completes in the following cycle.
- R4: A slow cycle starts only in a phase-0 cycle. `sb_cyc` then stays high for exactly 4 consecutive cycles. During the slow cycle `sb_addr` carries address bits 15:0, `sb_we` carries the write flag and `sb_wdata` carries the write data.
- R5: For a slow read, `sb_rdata` is captured in the last cycle of the slow cycle and appears on `cpu_rdata` in the cycle where `cpu_wait` is low.
- R6: With `turbo_off` high, an access to any bank other than the register page takes the slow path with the timing of R3.
- R7: The control register answers at bank 0xFF, address bits 15:8 equal to 0x80, for every offset in that page (full-page decode by default). It never stalls, including under `turbo_off`. Writing it loads data bit 0 into the software slow bit, and while that bit is 1 every other access takes the slow path. Bank 0xFF outside page 0x80 is fast memory.
- R8: Two slow cycles never start fewer than 4 fast cycles apart, including back-to-back slow writes.
- R9: `sb_clk` is low in phases 0 and 1 and high in phases 2 and 3.
- R10: `fm_en` is never high during a slow access or a register access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| turbo_off | input | 1 | Hardware switch forcing the slow path |
| cpu_req | input | 1 | Processor access valid this cycle |
| cpu_we | input | 1 | Access is a write |
| cpu_addr | input | 24 | Processor address, bank in bits 23:16 |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Read data returned to the processor |
| cpu_wait | output | 1 | Stall request to the processor |
| fm_en | output | 1 | Fast local memory access strobe |
| fm_we | output | 1 | Fast memory write |
| fm_addr | output | 24 | Fast memory address |
| fm_wdata | output | 8 | Fast memory write data |
| fm_rdata | input | 8 | Fast memory read data, combinational |
| sb_clk | output | 1 | Slow-bus clock, one quarter of the fast rate |
| sb_cyc | output | 1 | Slow-bus cycle active |
| sb_we | output | 1 | Slow-bus write |
| sb_addr | output | 16 | Slow-bus address |
| sb_wdata | output | 8 | Slow-bus write data |
| sb_rdata | input | 8 | Slow-bus read data |

## Verification
The assertions assume that the processor keeps `cpu_req`, `cpu_we`, `cpu_addr`, `cpu_wdata` and `turbo_off` stable while `cpu_wait` is high. They also assume the processor drops or changes the request only after the cycle in which the wait line falls. The stimulus drives inputs only on falling edges and holds them through the whole stall. It changes them only once a sample shows the wait line low. Every arrival phase is reached by idling until the bench's own phase model matches the wanted phase.

// File: rtl/turbo_sync_pkg.sv
package turbo_sync_pkg;

   typedef enum logic [1:0] {
      PATH_FAST = 2'd0,
      PATH_SLOW = 2'd1,
      PATH_REG  = 2'd2
   } path_t;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_ARM  = 2'd1,
      SQ_BUSY = 2'd2,
      SQ_DONE = 2'd3
   } seq_state_t;

endpackage

// File: rtl/tsync_phase.sv
module tsync_phase #(
   parameter int PH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PH_W-1:0] ph,
   output logic            sb_clk
);
   logic [PH_W-1:0] ph_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ph_q <= '0;
      else        ph_q <= ph_q + 1'b1;
   end

   assign ph     = ph_q;
   // slow clock is high for the upper half of the phase range
   assign sb_clk = ph_q[PH_W-1];
endmodule

// File: rtl/tsync_decode.sv
module tsync_decode
   import turbo_sync_pkg::*;
#(
   parameter int ADDR_W        = 24,
   parameter int LEG_W         = 16,
   parameter int SLOW_BANK     = 0,
   parameter int REG_BANK      = 'hFF,
   parameter int REG_PAGE      = 'h80,
   parameter bit REG_FULL_PAGE = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              turbo_off,
   input  logic              soft_slow,
   output path_t             path
);
   localparam int BANK_W = ADDR_W - LEG_W;
   localparam logic [BANK_W-1:0] SLOW_B = BANK_W'(SLOW_BANK);
   localparam logic [BANK_W-1:0] REG_B  = BANK_W'(REG_BANK);
   localparam logic [7:0]        REG_P  = 8'(REG_PAGE);

   logic [BANK_W-1:0] bank;
   logic [7:0]        page;
   logic [LEG_W-9:0]  offs;
   logic              reg_hit;
   logic              slow_hit;

   assign bank = addr[ADDR_W-1:LEG_W];
   assign page = addr[LEG_W-1:LEG_W-8];
   assign offs = addr[LEG_W-9:0];

   assign reg_hit  = (bank == REG_B) && (page == REG_P) &&
                     (REG_FULL_PAGE || (offs == '0));
   assign slow_hit = (bank == SLOW_B) || turbo_off || soft_slow;

   always_comb begin
      if (reg_hit)       path = PATH_REG;
      else if (slow_hit) path = PATH_SLOW;
      else               path = PATH_FAST;
   end
endmodule

// File: rtl/tsync_seq.sv
module tsync_seq
   import turbo_sync_pkg::*;
#(
   parameter int PH_W   = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PH_W-1:0]   ph,
   input  logic              slow_req,
   input  logic [DATA_W-1:0] sb_rdata,
   output logic              cpu_wait,
   output logic              sb_cyc,
   output logic [DATA_W-1:0] rd_q
);
   localparam int RATIO = 1 << PH_W;
   localparam int CW    = PH_W + 2;
   localparam logic [PH_W-1:0] PH_LAST   = '1;
   localparam logic [CW-1:0]   STALL_MIN = CW'(RATIO);
   localparam logic [CW-1:0]   STALL_CAP = CW'(2*RATIO - 2);
   localparam logic [CW-1:0]   GAP_SAT   = CW'(RATIO);

   seq_state_t st, st_nx;
   logic       launch_now;

   assign launch_now = (st == SQ_IDLE) && slow_req && (ph == '0);
   assign sb_cyc     = launch_now || (st == SQ_BUSY);
   assign cpu_wait   = slow_req && (st != SQ_DONE);

   always_comb begin
      st_nx = st;
      unique case (st)
         SQ_IDLE: if (slow_req)
                     st_nx = ((ph == '0) || (ph == PH_LAST)) ? SQ_BUSY : SQ_ARM;
         SQ_ARM:  if (ph == PH_LAST) st_nx = SQ_BUSY;
         SQ_BUSY: if (ph == PH_LAST) st_nx = SQ_DONE;
         SQ_DONE: st_nx = SQ_IDLE;
         default: st_nx = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= SQ_IDLE;
         rd_q <= '0;
      end else begin
         st <= st_nx;
         if (st == SQ_BUSY && ph == PH_LAST) rd_q <= sb_rdata;
      end
   end

   // checker state: stall length and distance between slow-cycle starts
   logic [CW-1:0] wait_cnt;
   logic [CW-1:0] gap_cnt;
   logic          cyc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_cnt <= '0;
         gap_cnt  <= GAP_SAT;
         cyc_q    <= 1'b0;
      end else begin
         cyc_q <= sb_cyc;
         if (st == SQ_DONE)  wait_cnt <= '0;
         else if (cpu_wait)  wait_cnt <= wait_cnt + 1'b1;
         if (sb_cyc && !cyc_q)      gap_cnt <= CW'(1);
         else if (gap_cnt < GAP_SAT) gap_cnt <= gap_cnt + 1'b1;
      end
   end

   assert_stall_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wait |-> (wait_cnt <= STALL_CAP));

   assert_stall_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_DONE) |-> (wait_cnt >= STALL_MIN));

   assert_launch_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_cyc && !cyc_q) |-> (ph == '0));

   assert_launch_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_cyc && !cyc_q) |-> (gap_cnt >= GAP_SAT));
endmodule

// File: rtl/turbo_bus_sync.sv
module turbo_bus_sync
   import turbo_sync_pkg::*;
#(
   parameter int         ADDR_W        = 24,
   parameter int         LEG_W         = 16,
   parameter int         DATA_W        = 8,
   parameter int         PH_W          = 2,
   parameter int         SLOW_BANK     = 0,
   parameter int         REG_BANK      = 'hFF,
   parameter int         REG_PAGE      = 'h80,
   parameter bit         REG_FULL_PAGE = 1'b1,
   parameter logic [6:0] ID_CODE       = 7'h2D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              turbo_off,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_wait,
   output logic              fm_en,
   output logic              fm_we,
   output logic [ADDR_W-1:0] fm_addr,
   output logic [DATA_W-1:0] fm_wdata,
   input  logic [DATA_W-1:0] fm_rdata,
   output logic              sb_clk,
   output logic              sb_cyc,
   output logic              sb_we,
   output logic [LEG_W-1:0]  sb_addr,
   output logic [DATA_W-1:0] sb_wdata,
   input  logic [DATA_W-1:0] sb_rdata
);
   localparam int ID_W = DATA_W - 1;

   generate
      if (ADDR_W < LEG_W + 1) begin : g_bad_addr
         $error("ADDR_W must leave at least one bank bit above LEG_W");
      end
      if (LEG_W < 9) begin : g_bad_leg
         $error("LEG_W must hold a page byte and an offset");
      end
      if (PH_W < 1 || PH_W > 4) begin : g_bad_ph
         $error("PH_W out of range 1..4");
      end
      if (DATA_W != 8) begin : g_bad_data
         $error("DATA_W must be 8 to hold the identity code and control bit");
      end
   endgenerate

   logic [PH_W-1:0]   ph;
   path_t             path;
   logic              soft_slow;
   logic              slow_req;
   logic [DATA_W-1:0] slow_rd;
   logic [DATA_W-1:0] reg_rd;

   tsync_phase #(.PH_W(PH_W)) phase_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .ph     (ph),
      .sb_clk (sb_clk)
   );

   tsync_decode #(
      .ADDR_W        (ADDR_W),
      .LEG_W         (LEG_W),
      .SLOW_BANK     (SLOW_BANK),
      .REG_BANK      (REG_BANK),
      .REG_PAGE      (REG_PAGE),
      .REG_FULL_PAGE (REG_FULL_PAGE)
   ) decode_i (
      .addr      (cpu_addr),
      .turbo_off (turbo_off),
      .soft_slow (soft_slow),
      .path      (path)
   );

   assign slow_req = cpu_req && (path == PATH_SLOW);

   tsync_seq #(.PH_W(PH_W), .DATA_W(DATA_W)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ph       (ph),
      .slow_req (slow_req),
      .sb_rdata (sb_rdata),
      .cpu_wait (cpu_wait),
      .sb_cyc   (sb_cyc),
      .rd_q     (slow_rd)
   );

   // identity / control register
   always_ff @(posedge clk) begin
      if (!rst_n) soft_slow <= 1'b0;
      else if (cpu_req && cpu_we && path == PATH_REG) soft_slow <= cpu_wdata[0];
   end
   assign reg_rd = {ID_CODE[ID_W-1:0], soft_slow};

   // fast local memory side
   assign fm_en    = cpu_req && (path == PATH_FAST);
   assign fm_we    = fm_en && cpu_we;
   assign fm_addr  = cpu_addr;
   assign fm_wdata = cpu_wdata;

   // legacy bus side, quiet outside a slow cycle
   assign sb_we    = sb_cyc && cpu_we;
   assign sb_addr  = sb_cyc ? cpu_addr[LEG_W-1:0] : '0;
   assign sb_wdata = sb_cyc ? cpu_wdata : '0;

   always_comb begin
      unique case (path)
         PATH_REG:  cpu_rdata = reg_rd;
         PATH_SLOW: cpu_rdata = slow_rd;
         default:   cpu_rdata = fm_rdata;
      endcase
   end

   assert_fast_nowait_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && path != PATH_SLOW) |-> !cpu_wait);

   assert_fm_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fm_en |-> !sb_cyc);

   assert_quiet_reset_R1: assert property (@(posedge clk)
      !rst_n |-> (!cpu_wait && !sb_cyc));
endmodule

// File: tb/turbo_bus_sync_tb_top.sv
module turbo_bus_sync_tb_top;
   localparam int RATIO = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        turbo_off, cpu_req, cpu_we;
   logic [23:0] cpu_addr;
   logic [7:0]  cpu_wdata, cpu_rdata;
   logic        cpu_wait;
   logic        fm_en, fm_we;
   logic [23:0] fm_addr;
   logic [7:0]  fm_wdata, fm_rdata;
   logic        sb_clk, sb_cyc, sb_we;
   logic [15:0] sb_addr;
   logic [7:0]  sb_wdata, sb_rdata;

   always #5 clk = ~clk;

   turbo_bus_sync dut_i (
      .clk(clk), .rst_n(rst_n), .turbo_off(turbo_off),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
      .fm_en(fm_en), .fm_we(fm_we), .fm_addr(fm_addr), .fm_wdata(fm_wdata),
      .fm_rdata(fm_rdata), .sb_clk(sb_clk), .sb_cyc(sb_cyc), .sb_we(sb_we),
      .sb_addr(sb_addr), .sb_wdata(sb_wdata), .sb_rdata(sb_rdata)
   );

   // memory models
   assign fm_rdata = fm_addr[7:0] + 8'h3C;
   assign sb_rdata = sb_cyc ? (sb_addr[7:0] ^ 8'hA5) : 8'h00;

   // bench phase model
   logic [1:0] bph;
   always_ff @(posedge clk) begin
      if (!rst_n) bph <= 2'd0;
      else        bph <= bph + 2'd1;
   end

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // slow-bus monitor
   logic        mon_prev = 1'b0;
   int          run_len = 0;
   int          since_launch = 1000;
   logic [15:0] mon_addr;
   logic        mon_we;
   logic [7:0]  mon_wd;

   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         chk(sb_clk == bph[1], "R9 slow clock level", 32'(sb_clk), 32'(bph[1]));
         if (sb_cyc && !mon_prev) begin
            chk(bph == 2'd0, "R4 slow cycle start phase", 32'(bph), 0);
            chk(since_launch >= RATIO, "R8 slow cycle spacing", since_launch, RATIO);
            since_launch = 0;
            run_len = 0;
            mon_addr = sb_addr;
            mon_we = sb_we;
            mon_wd = sb_wdata;
         end
         if (sb_cyc) run_len++;
         if (!sb_cyc && mon_prev)
            chk(run_len == RATIO, "R4 slow cycle length", run_len, RATIO);
         mon_prev = sb_cyc;
         since_launch++;
      end
   end

   // access driver
   int          stall;
   logic [7:0]  rd;
   logic        cap_fm_en, cap_fm_we, fm_seen;
   logic [23:0] cap_fm_addr;
   logic [7:0]  cap_fm_wd;
   logic [1:0]  arr_ph;

   task automatic access(input logic we, input logic [23:0] a,
                         input logic [7:0] d, input logic t);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; turbo_off = t;
      arr_ph = bph; stall = 0; fm_seen = 1'b0;
      for (int i = 0; i < 20; i++) begin
         #1;
         if (!cpu_wait) break;
         if (fm_en) fm_seen = 1'b1;
         stall++;
         @(negedge clk);
      end
      rd = cpu_rdata;
      cap_fm_en = fm_en; cap_fm_we = fm_we;
      cap_fm_addr = fm_addr; cap_fm_wd = fm_wdata;
      @(negedge clk);
   endtask

   task automatic go_idle();
      cpu_req = 1'b0; cpu_we = 1'b0; turbo_off = 1'b0;
   endtask

   task automatic align(input logic [1:0] p);
      while (bph != p) @(negedge clk);
   endtask

   function automatic int exp_stall(input logic [1:0] p);
      return (p == 2'd0) ? RATIO : 2*RATIO - int'(p);
   endfunction

   // {we, addr, wdata, turbo_off, arrival phase, slow expected}
   localparam logic [36:0] VEC [0:10] = '{
      {1'b0, 24'h00D012, 8'h00, 1'b0, 2'd0, 1'b1},
      {1'b0, 24'h00D40B, 8'h00, 1'b0, 2'd1, 1'b1},
      {1'b0, 24'h00E000, 8'h00, 1'b0, 2'd2, 1'b1},
      {1'b0, 24'h00C123, 8'h00, 1'b0, 2'd3, 1'b1},
      {1'b1, 24'h00D01A, 8'h44, 1'b0, 2'd2, 1'b1},
      {1'b0, 24'h010200, 8'h00, 1'b0, 2'd1, 1'b0},
      {1'b1, 24'h3F0011, 8'h77, 1'b0, 2'd0, 1'b0},
      {1'b0, 24'hFF7F00, 8'h00, 1'b0, 2'd3, 1'b0},
      {1'b0, 24'h400055, 8'h00, 1'b1, 2'd1, 1'b1},
      {1'b1, 24'h800066, 8'h99, 1'b1, 2'd3, 1'b1},
      {1'b0, 24'hFE8000, 8'h00, 1'b0, 2'd0, 1'b0}
   };

   initial begin
      rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; turbo_off = 1'b0;
      cpu_addr = '0; cpu_wdata = '0;
      repeat (3) @(negedge clk);
      #1;
      chk(cpu_wait == 1'b0, "R1 wait low in reset", 32'(cpu_wait), 0);
      chk(sb_cyc == 1'b0, "R1 slow cycle idle in reset", 32'(sb_cyc), 0);
      @(negedge clk);
      rst_n = 1'b1;

      access(1'b0, 24'hFF8000, 8'h00, 1'b0);
      chk(stall == 0, "R1 register read no stall", stall, 0);
      chk(rd == 8'h5A, "R1 register reset value", rd, 8'h5A);
      go_idle(); @(negedge clk);

      foreach (VEC[i]) begin
         logic        v_we, v_t, v_slow;
         logic [23:0] v_a;
         logic [7:0]  v_d, exp_rd;
         logic [1:0]  v_p;
         string       tag;
         v_we = VEC[i][36]; v_a = VEC[i][35:12]; v_d = VEC[i][11:4];
         v_t = VEC[i][3]; v_p = VEC[i][2:1]; v_slow = VEC[i][0];
         tag = v_slow ? (v_t ? "R6" : "R3") : "R2";
         align(v_p);
         access(v_we, v_a, v_d, v_t);
         chk(stall == (v_slow ? exp_stall(v_p) : 0), {tag, " stall length"},
             stall, v_slow ? exp_stall(v_p) : 0);
         if (v_slow) begin
            chk(!fm_seen && !cap_fm_en, "R10 no fast strobe on slow access",
                32'(fm_seen | cap_fm_en), 0);
            chk(mon_addr == v_a[15:0] && mon_we == v_we,
                "R4 slow bus address and direction", {15'd0, mon_we, mon_addr},
                {15'd0, v_we, v_a[15:0]});
            if (v_we) chk(mon_wd == v_d, "R4 slow bus write data", mon_wd, v_d);
            else begin
               exp_rd = v_a[7:0] ^ 8'hA5;
               chk(rd == exp_rd, "R5 slow read data", rd, exp_rd);
            end
         end else begin
            chk(cap_fm_en && cap_fm_we == v_we && cap_fm_addr == v_a,
                "R2 fast strobe and address", {7'd0, cap_fm_en, cap_fm_addr},
                {7'd0, 1'b1, v_a});
            if (v_we) chk(cap_fm_wd == v_d, "R2 fast write data", cap_fm_wd, v_d);
            else begin
               exp_rd = v_a[7:0] + 8'h3C;
               chk(rd == exp_rd, "R2 fast read data", rd, exp_rd);
            end
         end
         go_idle(); @(negedge clk);
      end

      // R7: full-page decode and turbo-off immunity
      access(1'b0, 24'hFF80A7, 8'h00, 1'b0);
      chk(stall == 0 && rd == 8'h5A, "R7 register page offset", {stall[23:0], rd}, 32'h5A);
      go_idle(); @(negedge clk);
      access(1'b0, 24'hFF8000, 8'h00, 1'b1);
      chk(stall == 0, "R7 register not slowed by turbo_off", stall, 0);
      go_idle(); @(negedge clk);

      // R7: software slow bit
      access(1'b1, 24'hFF8000, 8'h01, 1'b0);
      chk(stall == 0, "R7 register write no stall", stall, 0);
      go_idle(); @(negedge clk);
      align(2'd2);
      access(1'b0, 24'h050000, 8'h00, 1'b0);
      chk(stall == 6, "R7 soft slow forces stall", stall, 6);
      chk(rd == 8'hA5, "R7 soft slow read from slow bus", rd, 8'hA5);
      go_idle(); @(negedge clk);
      access(1'b0, 24'hFF8000, 8'h00, 1'b0);
      chk(rd == 8'h5B, "R7 control bit read back", rd, 8'h5B);
      go_idle(); @(negedge clk);
      access(1'b1, 24'hFF8000, 8'h00, 1'b0);
      go_idle(); @(negedge clk);
      access(1'b0, 24'h050000, 8'h00, 1'b0);
      chk(stall == 0 && rd == 8'h3C, "R7 soft slow cleared", {stall[23:0], rd}, 32'h3C);
      go_idle(); @(negedge clk);

      // R8: back-to-back slow writes
      align(2'd3);
      access(1'b1, 24'h00D40A, 8'h11, 1'b0);
      chk(stall == 5, "R8 first write stall", stall, 5);
      access(1'b1, 24'h00D40B, 8'h22, 1'b0);
      chk(stall == 7, "R8 second write waits for next boundary", stall, 7);
      chk(mon_addr == 16'hD40B && mon_wd == 8'h22, "R8 second write on bus",
          {8'd0, mon_addr, mon_wd}, 32'hD40B22);
      go_idle();
      repeat (6) @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule